// File: doc/BRIEF.md
# DRAM Channel Selector and Address Normalizer

This block sits after node decode in a memory controller front end. It receives a system address that is already known to belong to the local node. It decides which of the two DRAM controller channels serves that address. It then turns the address into a channel-relative DRAM address: it subtracts the right base offset and removes the address bits that node interleaving and channel interleaving consumed.

Channel choice follows a fixed priority. Ganged operation comes first, then the upper address region, then three interleave styles (a fixed low bit, a fixed bit above the node-interleave bits, and a parity hash), and finally a static assignment. The base offset comes from the DRAM hole relocation, the upper-region offset or the node base, depending on the region and on whether the address lies above 4 GiB. The datapath is combinational. A parameter adds an output register with a one-cycle latency.

Top module: `dram_chan_norm`

## Requirements
- R1: The upper region is active when `hi_rng_en` is 1, `gang_en` is 0 and `sys_addr` is at least `sel_base_fld` shifted left by 27.
- R2: With `gang_en` set, `chan` equals `sys_addr[3]`, whatever the other mode inputs are, and no channel-interleave bit is removed.
- R3: In the upper region (R1), `chan` equals `hi_chan` and no channel-interleave bit is removed.
- R4: Outside ganging and the upper region, with `ilv_en` set and `ilv_mode` = 0, `chan` equals `sys_addr[6]` and bit 6 is removed from the normalized address.
- R5: With `ilv_en` set and `ilv_mode` = 2 or 3 (no ganging, no upper region), `chan` is the XOR parity of `sys_addr[20:16]` XORed with `sys_addr[6]` (mode 2) or `sys_addr[9]` (mode 3). Bit 6 (mode 2) or bit 9 (mode 3) is removed.
- R6: With `ilv_en` set and `ilv_mode` = 1 (no ganging, no upper region), `chan` equals `sys_addr[12 + ilv_log]`. Bit 12 of the address is removed after node-interleave removal.
- R7: Without ganging, upper region or interleave, `chan` is the inverse of `hi_chan` when `hi_rng_en` is 1, and 0 otherwise.
- R8: In the upper region the subtracted offset is `hole_ofs_fld`<<23 when the upper base is below `hole_base_fld`<<24, `hole_valid` is 1 and `sys_addr` ≥ 2^32. In every other upper-region case it is `sel_ofs_fld`<<26.
- R9: Outside the upper region the offset is `hole_ofs_fld`<<23 when `hole_valid` is 1 and `sys_addr` ≥ 2^32. Otherwise it is `node_base_fld`<<24.
- R10: When `ilv_log` is non-zero, the address bits from bit 12 up to bit 12+`ilv_log`-1 are removed from the offset-corrected address. Bits 11:0 are kept and the higher bits shift down.
- R11: With the output register enabled, `chan` and `chan_addr` reflect the inputs of the previous clock edge, and both read 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_addr | input | ADDR_W | Node-resolved system address |
| ilv_log | input | 2 | Number of node-interleave bits (0 = none) |
| hole_valid | input | 1 | DRAM hole relocation active |
| hole_base_fld | input | 8 | Hole base, address bits 31:24 |
| hole_ofs_fld | input | 9 | Hole offset, address bits 31:23 |
| node_base_fld | input | ADDR_W-24 | Node DRAM base, address bits from 24 up |
| gang_en | input | 1 | Both channels operate as one |
| hi_rng_en | input | 1 | Upper address region enable |
| hi_chan | input | 1 | Channel assigned to the upper region |
| ilv_en | input | 1 | Channel interleave enable |
| ilv_mode | input | 2 | Interleave style: 0 bit 6, 1 bit 12+log, 2 hash with bit 6, 3 hash with bit 9 |
| sel_base_fld | input | ADDR_W-27 | Upper region base, address bits from 27 up |
| sel_ofs_fld | input | ADDR_W-26 | Upper region offset, address bits from 26 up |
| chan | output | 1 | Selected channel |
| chan_addr | output | ADDR_W | Normalized channel address |

## Verification
The bench goes after the priority order: ganging set together with interleave and the upper region, where a wrong order would pick bit 6 or `hi_chan` instead of bit 3. It probes addresses just below and at the upper base, where an off-by-one compare swaps both the channel and the offset. It probes the hole offset just under and over 4 GiB, and an upper base on either side of the hole base, where a wrong condition subtracts the wrong base. Non-zero interleave logs combined with mode 1 expose a design that removes the channel bit before the node bits or removes the wrong bit. Such a design returns an address shifted by one position.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
   localparam int unsigned NODE_LSB     = 12;
   localparam int unsigned GANG_BIT     = 3;
   localparam int unsigned LOW_BIT      = 6;
   localparam int unsigned MID_BIT      = 9;
   localparam int unsigned HASH_LO      = 16;
   localparam int unsigned HASH_HI      = 20;
   localparam int unsigned SEL_BASE_LSB = 27;
   localparam int unsigned SEL_OFS_LSB  = 26;
   localparam int unsigned NODE_B_LSB   = 24;
   localparam int unsigned HOLE_B_LSB   = 24;
   localparam int unsigned HOLE_O_LSB   = 23;
   localparam int unsigned HOLE_B_W     = 8;
   localparam int unsigned HOLE_O_W     = 9;
   localparam int unsigned FOUR_G_BIT   = 32;

   typedef enum logic [1:0] {
      ILV_BIT6  = 2'd0,
      ILV_BITHI = 2'd1,
      ILV_HASH6 = 2'd2,
      ILV_HASH9 = 2'd3
   } ilv_mode_e;
endpackage

// File: rtl/dcs_chan_pick.sv
module dcs_chan_pick
   import dcs_pkg::*;
#(
   parameter int unsigned ADDR_W = 48,
   parameter int unsigned ILOG_W = 2
) (
   input  logic [ADDR_W-1:0] sys_addr,
   input  logic [ILOG_W-1:0] ilv_log,
   input  logic              gang_en,
   input  logic              hi_sel,
   input  logic              hi_rng_en,
   input  logic              hi_chan,
   input  logic              ilv_en,
   input  logic [1:0]        ilv_mode,
   output logic              chan
);
   logic hash_par;
   logic hash_mix;
   logic hi_bit;

   assign hash_par = ^sys_addr[HASH_HI:HASH_LO];
   assign hash_mix = hash_par ^ (ilv_mode[0] ? sys_addr[MID_BIT] : sys_addr[LOW_BIT]);
   assign hi_bit   = sys_addr[NODE_LSB + int'(ilv_log)];

   always_comb begin
      if (gang_en)                             chan = sys_addr[GANG_BIT];
      else if (hi_sel)                         chan = hi_chan;
      else if (ilv_en && ilv_mode == ILV_BIT6) chan = sys_addr[LOW_BIT];
      else if (ilv_en && ilv_mode[1])          chan = hash_mix;
      else if (ilv_en)                         chan = hi_bit;
      else if (hi_rng_en)                      chan = ~hi_chan;
      else                                     chan = 1'b0;
   end
endmodule

// File: rtl/dcs_offset_pick.sv
module dcs_offset_pick
   import dcs_pkg::*;
#(
   parameter int unsigned ADDR_W = 48
) (
   input  logic [ADDR_W-1:0]            sys_addr,
   input  logic                         hi_sel,
   input  logic                         hole_valid,
   input  logic [HOLE_B_W-1:0]          hole_base_fld,
   input  logic [HOLE_O_W-1:0]          hole_ofs_fld,
   input  logic [ADDR_W-1:0]            sel_base,
   input  logic [ADDR_W-SEL_OFS_LSB-1:0] sel_ofs_fld,
   input  logic [ADDR_W-NODE_B_LSB-1:0] node_base_fld,
   output logic [ADDR_W-1:0]            offset
);
   localparam int unsigned PAD_W = ADDR_W - FOUR_G_BIT;

   logic [ADDR_W-1:0] hole_base;
   logic [ADDR_W-1:0] hole_ofs;
   logic [ADDR_W-1:0] sel_ofs;
   logic [ADDR_W-1:0] node_base;
   logic              above_4g;
   logic              use_hole;

   assign hole_base = {{PAD_W{1'b0}}, hole_base_fld, {HOLE_B_LSB{1'b0}}};
   assign hole_ofs  = {{PAD_W{1'b0}}, hole_ofs_fld, {HOLE_O_LSB{1'b0}}};
   assign sel_ofs   = {sel_ofs_fld, {SEL_OFS_LSB{1'b0}}};
   assign node_base = {node_base_fld, {NODE_B_LSB{1'b0}}};
   assign above_4g  = |sys_addr[ADDR_W-1:FOUR_G_BIT];

   always_comb begin
      if (hi_sel) use_hole = hole_valid && above_4g && (sel_base < hole_base);
      else        use_hole = hole_valid && above_4g;
      if (use_hole)    offset = hole_ofs;
      else if (hi_sel) offset = sel_ofs;
      else             offset = node_base;
   end
endmodule

// File: rtl/dcs_squeeze.sv
module dcs_squeeze
   import dcs_pkg::*;
#(
   parameter int unsigned ADDR_W = 48,
   parameter int unsigned ILOG_W = 2
) (
   input  logic [ADDR_W-1:0] sys_addr,
   input  logic [ADDR_W-1:0] offset,
   input  logic [ILOG_W-1:0] ilv_log,
   input  logic              ilv_en,
   input  logic              hi_sel,
   input  logic              gang_en,
   input  logic [1:0]        ilv_mode,
   output logic [ADDR_W-1:0] chan_addr
);
   logic [ADDR_W-1:0] rel;
   logic [ADDR_W-1:0] no_node;
   logic [ADDR_W-1:0] drop6;
   logic [ADDR_W-1:0] drop9;
   logic [ADDR_W-1:0] drop12;

   function automatic logic [ADDR_W-1:0] drop_at(input logic [ADDR_W-1:0] a,
                                                 input int unsigned pos);
      logic [ADDR_W-1:0] keep_mask;
      keep_mask = ({ADDR_W{1'b1}} << pos);
      return ((a >> (pos + 1)) << pos) | (a & ~keep_mask);
   endfunction

   assign rel = sys_addr - offset;

   always_comb begin
      if (ilv_log != '0)
         no_node = ((rel >> (NODE_LSB + int'(ilv_log))) << NODE_LSB)
                   | {{(ADDR_W-NODE_LSB){1'b0}}, rel[NODE_LSB-1:0]};
      else
         no_node = rel;
   end

   assign drop6  = drop_at(no_node, LOW_BIT);
   assign drop9  = drop_at(no_node, MID_BIT);
   assign drop12 = drop_at(no_node, NODE_LSB);

   always_comb begin
      if (!ilv_en || hi_sel || gang_en) chan_addr = no_node;
      else if (!ilv_mode[0])            chan_addr = drop6;
      else if (ilv_mode == ILV_BITHI)   chan_addr = drop12;
      else                              chan_addr = drop9;
   end
endmodule

// File: rtl/dram_chan_norm.sv
module dram_chan_norm
   import dcs_pkg::*;
#(
   parameter int unsigned ADDR_W  = 48,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             sys_addr,
   input  logic [1:0]                    ilv_log,
   input  logic                          hole_valid,
   input  logic [7:0]                    hole_base_fld,
   input  logic [8:0]                    hole_ofs_fld,
   input  logic [ADDR_W-25:0]            node_base_fld,
   input  logic                          gang_en,
   input  logic                          hi_rng_en,
   input  logic                          hi_chan,
   input  logic                          ilv_en,
   input  logic [1:0]                    ilv_mode,
   input  logic [ADDR_W-28:0]            sel_base_fld,
   input  logic [ADDR_W-27:0]            sel_ofs_fld,
   output logic                          chan,
   output logic [ADDR_W-1:0]             chan_addr
);
   localparam int unsigned ILOG_W  = 2;
   localparam int unsigned MIN_W   = FOUR_G_BIT + 8;

   generate
      if (ADDR_W < MIN_W) begin : g_bad_width
         $error("dram_chan_norm: ADDR_W must be at least %0d", MIN_W);
      end
      if (NODE_LSB + (1 << ILOG_W) > HASH_LO) begin : g_bad_log
         $error("dram_chan_norm: node interleave bits overlap the hash field");
      end
   endgenerate

   logic [ADDR_W-1:0] sel_base;
   logic              hi_sel;
   logic              chan_nxt;
   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] addr_nxt;

   assign sel_base = {sel_base_fld, {SEL_BASE_LSB{1'b0}}};
   assign hi_sel   = hi_rng_en && !gang_en && (sys_addr >= sel_base);

   dcs_chan_pick #(.ADDR_W(ADDR_W), .ILOG_W(ILOG_W)) u_pick (
      .sys_addr  (sys_addr),
      .ilv_log   (ilv_log),
      .gang_en   (gang_en),
      .hi_sel    (hi_sel),
      .hi_rng_en (hi_rng_en),
      .hi_chan   (hi_chan),
      .ilv_en    (ilv_en),
      .ilv_mode  (ilv_mode),
      .chan      (chan_nxt)
   );

   dcs_offset_pick #(.ADDR_W(ADDR_W)) u_ofs (
      .sys_addr      (sys_addr),
      .hi_sel        (hi_sel),
      .hole_valid    (hole_valid),
      .hole_base_fld (hole_base_fld),
      .hole_ofs_fld  (hole_ofs_fld),
      .sel_base      (sel_base),
      .sel_ofs_fld   (sel_ofs_fld),
      .node_base_fld (node_base_fld),
      .offset        (offset)
   );

   dcs_squeeze #(.ADDR_W(ADDR_W), .ILOG_W(ILOG_W)) u_sqz (
      .sys_addr  (sys_addr),
      .offset    (offset),
      .ilv_log   (ilv_log),
      .ilv_en    (ilv_en),
      .hi_sel    (hi_sel),
      .gang_en   (gang_en),
      .ilv_mode  (ilv_mode),
      .chan_addr (addr_nxt)
   );

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chan      <= 1'b0;
               chan_addr <= '0;
            end else begin
               chan      <= chan_nxt;
               chan_addr <= addr_nxt;
            end
         end
      end else begin : g_comb
         assign chan      = chan_nxt;
         assign chan_addr = addr_nxt;
      end
   endgenerate
endmodule

// File: rtl/dram_chan_norm_chk.sv
module dram_chan_norm_chk #(
   parameter int unsigned ADDR_W  = 48,
   parameter bit          REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] sys_addr,
   input logic              gang_en,
   input logic              hi_rng_en,
   input logic              hi_chan,
   input logic              ilv_en,
   input logic [1:0]        ilv_mode,
   input logic [ADDR_W-28:0] sel_base_fld,
   input logic              chan_nxt,
   input logic [ADDR_W-1:0] addr_nxt,
   input logic              chan,
   input logic [ADDR_W-1:0] chan_addr
);
   logic [ADDR_W-1:0] base_full;
   logic              in_hi;
   assign base_full = {sel_base_fld, 27'b0};
   assign in_hi     = hi_rng_en && !gang_en && (sys_addr >= base_full);

   a_r2_gang_bit3: assert property (@(posedge clk) disable iff (!rst_n)
      gang_en |-> chan_nxt == sys_addr[3]);

   a_r3_hi_region: assert property (@(posedge clk) disable iff (!rst_n)
      in_hi |-> chan_nxt == hi_chan);

   a_r4_low_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (!gang_en && !in_hi && ilv_en && ilv_mode == 2'd0) |-> chan_nxt == sys_addr[6]);

   a_r7_static: assert property (@(posedge clk) disable iff (!rst_n)
      (!gang_en && !hi_rng_en && !ilv_en) |-> !chan_nxt);

   generate
      if (REG_OUT) begin : g_reg_chk
         a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (chan == $past(chan_nxt)) && (chan_addr == $past(addr_nxt)));
      end
   endgenerate
endmodule

bind dram_chan_norm dram_chan_norm_chk #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sys_addr     (sys_addr),
   .gang_en      (gang_en),
   .hi_rng_en    (hi_rng_en),
   .hi_chan      (hi_chan),
   .ilv_en       (ilv_en),
   .ilv_mode     (ilv_mode),
   .sel_base_fld (sel_base_fld),
   .chan_nxt     (chan_nxt),
   .addr_nxt     (addr_nxt),
   .chan         (chan),
   .chan_addr    (chan_addr)
);

// File: tb/dram_chan_norm_test.sv
module dram_chan_norm_test;
   localparam int AW = 48;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] sys_addr = '0;
   logic [1:0]    ilv_log = '0;
   logic          hole_valid = 1'b0;
   logic [7:0]    hole_base_fld = '0;
   logic [8:0]    hole_ofs_fld = '0;
   logic [AW-25:0] node_base_fld = '0;
   logic          gang_en = 1'b0;
   logic          hi_rng_en = 1'b0;
   logic          hi_chan = 1'b0;
   logic          ilv_en = 1'b0;
   logic [1:0]    ilv_mode = '0;
   logic [AW-28:0] sel_base_fld = '0;
   logic [AW-27:0] sel_ofs_fld = '0;
   logic          chan;
   logic [AW-1:0] chan_addr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      string         tag;
      logic          ch;
      logic [AW-1:0] ad;
   } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;

   dram_chan_norm #(.ADDR_W(AW), .REG_OUT(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .sys_addr(sys_addr), .ilv_log(ilv_log),
      .hole_valid(hole_valid), .hole_base_fld(hole_base_fld),
      .hole_ofs_fld(hole_ofs_fld), .node_base_fld(node_base_fld),
      .gang_en(gang_en), .hi_rng_en(hi_rng_en), .hi_chan(hi_chan),
      .ilv_en(ilv_en), .ilv_mode(ilv_mode), .sel_base_fld(sel_base_fld),
      .sel_ofs_fld(sel_ofs_fld), .chan(chan), .chan_addr(chan_addr)
   );

   function automatic logic [AW-1:0] cut(input logic [AW-1:0] a, input int p);
      logic [AW-1:0] lo;
      lo = a & ((48'd1 << p) - 48'd1);
      return ((a >> (p + 1)) << p) | lo;
   endfunction

   function automatic exp_t model(input string tag);
      exp_t e;
      logic [AW-1:0] sb_full, hb, ho, off, a;
      logic hi, big, par;
      sb_full = {sel_base_fld, 27'b0};
      hi  = hi_rng_en && !gang_en && (sys_addr >= sb_full);
      par = ^sys_addr[20:16];
      big = sys_addr >= 48'h1_0000_0000;
      if (gang_en)                       e.ch = sys_addr[3];
      else if (hi)                       e.ch = hi_chan;
      else if (ilv_en && ilv_mode == 0)  e.ch = sys_addr[6];
      else if (ilv_en && ilv_mode == 2)  e.ch = par ^ sys_addr[6];
      else if (ilv_en && ilv_mode == 3)  e.ch = par ^ sys_addr[9];
      else if (ilv_en)                   e.ch = sys_addr[12 + ilv_log];
      else if (hi_rng_en)                e.ch = !hi_chan;
      else                               e.ch = 1'b0;
      hb = 48'(hole_base_fld) << 24;
      ho = 48'(hole_ofs_fld) << 23;
      if (hi) off = (sb_full < hb && hole_valid && big) ? ho : (48'(sel_ofs_fld) << 26);
      else    off = (hole_valid && big) ? ho : (48'(node_base_fld) << 24);
      a = sys_addr - off;
      if (ilv_log != 0) a = ((a >> (12 + ilv_log)) << 12) | (a & 48'hFFF);
      if (ilv_en && !hi && !gang_en) begin
         if (ilv_mode == 0 || ilv_mode == 2) a = cut(a, 6);
         else if (ilv_mode == 1)             a = cut(a, 12);
         else                                a = cut(a, 9);
      end
      e.ad = a;
      e.tag = tag;
      return e;
   endfunction

   task automatic apply(input string tag);
      sb.push_back(model(tag));
      @(negedge clk);
   endtask

   task automatic clear_cfg();
      ilv_log = 0; hole_valid = 0; hole_base_fld = 0; hole_ofs_fld = 0;
      node_base_fld = 0; gang_en = 0; hi_rng_en = 0; hi_chan = 0;
      ilv_en = 0; ilv_mode = 0; sel_base_fld = 0; sel_ofs_fld = 0;
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   // monitor: compare one cycle after each pushed vector was registered
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (chan !== e.ch || chan_addr !== e.ad) begin
               fails++;
               $display("FAIL %s: chan=%0d addr=%h expected chan=%0d addr=%h",
                        e.tag, chan, chan_addr, e.ch, e.ad);
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         report();
      end
   end

   initial begin
      // R11: reset state, register held while reset stays low
      sys_addr = 48'h0000_1234_5678;
      gang_en  = 1'b1;
      repeat (3) @(negedge clk);
      checks++;
      if (chan !== 1'b0 || chan_addr !== '0) begin
         fails++;
         $display("FAIL R11: chan=%0d addr=%h expected chan=0 addr=0", chan, chan_addr);
      end
      rst_n = 1'b1;
      clear_cfg();
      @(negedge clk);

      // R7/R9: plain pass-through, node base subtracted
      sys_addr = 48'h0000_1234_5678; node_base_fld = 24'h000010;
      apply("R9");
      hi_rng_en = 1; hi_chan = 1; sel_base_fld = 21'd4;
      sys_addr = 48'h0000_1FFF_FFFF;
      apply("R7");
      hi_rng_en = 0;
      apply("R7");

      // R1/R3/R8: upper region edge
      clear_cfg();
      hi_rng_en = 1; hi_chan = 1; sel_base_fld = 21'd2; sel_ofs_fld = 22'd1; ilv_en = 1;
      sys_addr = 48'h0000_1000_0040;
      apply("R3");
      sys_addr = 48'h0000_0FFF_FFC0;
      apply("R1");
      hi_chan = 0; sys_addr = 48'h0000_1800_0248;
      apply("R8");

      // R2: ganged beats everything
      gang_en = 1; ilv_mode = 2; sys_addr = 48'h0000_1800_0048;
      apply("R2");
      sys_addr = 48'h0000_1800_0040;
      apply("R2");

      // R4: bit 6 select and removal
      clear_cfg();
      ilv_en = 1; ilv_mode = 0;
      sys_addr = 48'h0000_0000_0FC7;
      apply("R4");
      sys_addr = 48'h0000_ABCD_EF3F;
      apply("R4");

      // R5: hashed modes
      ilv_mode = 2; sys_addr = 48'h0000_0015_0240;
      apply("R5");
      ilv_mode = 3; sys_addr = 48'h0000_0013_0240;
      apply("R5");
      sys_addr = 48'h0000_001F_0200;
      apply("R5");

      // R6/R10: mode 1 with node interleave
      ilv_mode = 1; ilv_log = 0; sys_addr = 48'h0000_0000_3ABC;
      apply("R6");
      ilv_log = 2; sys_addr = 48'h0000_0000_4ABC;
      apply("R6");
      ilv_en = 0; ilv_log = 3; sys_addr = 48'h0000_1234_FABC;
      apply("R10");
      ilv_log = 1;
      apply("R10");

      // R8/R9: hole offset around 4 GiB
      clear_cfg();
      hole_valid = 1; hole_base_fld = 8'hC0; hole_ofs_fld = 9'h080; node_base_fld = 24'h000001;
      sys_addr = 48'h0000_FFFF_FFF0;
      apply("R9");
      sys_addr = 48'h0001_0000_0010;
      apply("R9");
      hi_rng_en = 1; sel_base_fld = 21'd16; sel_ofs_fld = 22'd4;
      apply("R8");
      sel_base_fld = 21'd40;
      sys_addr = 48'h0001_4000_0010;
      apply("R8");

      // mixed random configurations, checked against the requirement model
      for (int i = 0; i < 400; i++) begin
         sys_addr      = {$urandom(), $urandom()} & 48'h0003_FFFF_FFFF;
         ilv_log       = 2'($urandom());
         hole_valid    = 1'($urandom());
         hole_base_fld = 8'($urandom());
         hole_ofs_fld  = 9'($urandom());
         node_base_fld = 24'($urandom() & 32'hFF);
         gang_en       = ($urandom() % 6) == 0;
         hi_rng_en     = 1'($urandom());
         hi_chan       = 1'($urandom());
         ilv_en        = 1'($urandom());
         ilv_mode      = 2'($urandom());
         sel_base_fld  = 21'($urandom() & 32'h3F);
         sel_ofs_fld   = 22'($urandom() & 32'h7F);
         apply("R9");
      end
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      report();
   end
endmodule